// File: doc/BRIEF.md
# Four-State Strap Address Decoder

This block works out what each of two strap pins is wired to: ground, supply, the bus clock line or the bus data line. While a bus transmission is open it compares every pin sample against the sampled SCL and SDA levels. At STOP it turns the result into a 2-bit code per pin. It does this for every transmission on the bus, including ones meant for other devices, so the strapping can change while the device runs without a power cycle.

The two codes set the configuration of a port-expander style device:
- a 7-bit slave address for the input function;
- a 7-bit slave address for the output function;
- pullup enables for the input ports, in two groups of four;
- power-up default levels for eight outputs, in two groups of four.

Until the first transmission has been decoded, the block cannot tell a bus-tied pin from a fixed one. In that window it follows the plain pin levels, so a pin on a bus line that idles high reads as tied-high. The pin levels, SCL, SDA and the one-cycle START/STOP pulses are all expected to be synchronous to `clk` already.

Top module: `strap_addr_decoder`

## Requirements
- R1: While `rst_n` is low, the outputs are forced as follows: `cfg_valid`=0, `in_addr`=0x6F, `out_addr`=0x5F, `pull_en`=0xFF and `dflt_out`=0xFF. These values correspond to both pin codes being tied-high (code 11).
- R2: Until the first commit, each pin's code is 11 when its level is 1 and 10 when it is 0. The code follows the pin with one clock of delay, whatever the bus is doing.
- R3: A pin is classified as clock-tied (code 00) when two conditions both hold. It equals SCL on every sample from the START cycle through the cycle before STOP, and SCL changed at least once across those samples. When both bus lines qualify, this code wins.
- R4: A pin is classified as data-tied (code 01) under the same rule as R3, with SDA in place of SCL.
- R5: Any other pin is classified as a fixed level: code 11 if the pin is 1 in the STOP cycle, 10 if it is 0. This includes a pin that matches a bus line which never toggled during the transmission.
- R6: A STOP pulse while a transmission is open commits the new codes.
  - The outputs change on that same clock edge, and `cfg_valid` rises and stays high.
  - After the first commit the outputs hold between commits.
  - A STOP with no open transmission is ignored.
  - A START while a transmission is open does not restart the sampling.
- R7: The input function address is `in_addr` = {110, code of pin 1, code of pin 0}. The output function address is `out_addr` = {101, same four bits}. Pin 0's code is in bits 1:0.
- R8: `pull_en[3:0]` (inputs 0–3) is all zeros when pin 0's code is 10 and all ones otherwise. `pull_en[7:4]` (inputs 4–7) follows pin 1's code the same way.
- R9: `dflt_out[3:0]` (outputs 8–11) is all zeros when pin 0's code is 10 and all ones otherwise. `dflt_out[7:4]` (outputs 12–15) follows pin 1's code the same way.
- R10: Every completed transmission refreshes the decode. A later transmission with different strapping replaces an earlier result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 2 | Synchronized strap pin levels, bit 0 = first pin |
| scl | input | 1 | Sampled bus clock line level |
| sda | input | 1 | Sampled bus data line level |
| start_pulse | input | 1 | One-cycle START event |
| stop_pulse | input | 1 | One-cycle STOP event |
| cfg_valid | output | 1 | High once a transmission has been decoded |
| in_addr | output | 7 | Input function slave address |
| out_addr | output | 7 | Output function slave address |
| pull_en | output | 8 | Input pullup enables, one per input |
| dflt_out | output | 8 | Default levels for outputs 8–15 |

## Verification
The assertions check four things on every cycle:
- the address prefixes and the shared code bits between the two addresses;
- that the pullup and default groups agree with the code bits in the address;
- that a rise of the valid flag follows a STOP, and the flag stays up;
- that the outputs hold between commits, and that only high or low codes appear before the first commit.

Which bus line a pin is tied to can only be shown by the bench's transmissions. Its scenarios cover clock-tied and data-tied pins, fixed levels, a pin on a bus line that never toggles, the tie between two identical bus lines, a stray STOP and a repeated START. A behavioural reference model is compared with every output on every clock.

// File: rtl/strap_pkg.sv
package strap_pkg;

   localparam int STRAP_CODE_W = 2;

   // 2-bit classification code of one strap pin
   typedef enum logic [STRAP_CODE_W-1:0] {
      STRAP_CLK  = 2'b00,
      STRAP_DAT  = 2'b01,
      STRAP_LOW  = 2'b10,
      STRAP_HIGH = 2'b11
   } strap_code_e;

   // Code used for a pin seen at a fixed level
   function automatic strap_code_e strap_fixed(input logic lvl);
      return lvl ? STRAP_HIGH : STRAP_LOW;
   endfunction

endpackage

// File: rtl/strap_txn_track.sv
module strap_txn_track (
   input  logic clk,
   input  logic rst_n,
   input  logic start_pulse,
   input  logic stop_pulse,
   output logic first_smp,
   output logic more_smp,
   output logic commit
);

   logic open_q;

   // A START opens a window only when none is open; a repeated START keeps sampling
   assign first_smp = start_pulse & ~open_q;
   assign more_smp  = open_q & ~stop_pulse;
   assign commit    = open_q & stop_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (commit) begin
         open_q <= 1'b0;
      end else if (first_smp) begin
         open_q <= 1'b1;
      end
   end

endmodule

// File: rtl/strap_pin_class.sv
module strap_pin_class
   import strap_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        first_smp,
   input  logic        more_smp,
   input  logic        pin,
   input  logic        scl,
   input  logic        sda,
   output strap_code_e code_o
);

   logic same_clk_q, same_dat_q;
   logic tog_clk_q, tog_dat_q;
   logic last_clk_q, last_dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         same_clk_q <= 1'b0;
         same_dat_q <= 1'b0;
         tog_clk_q  <= 1'b0;
         tog_dat_q  <= 1'b0;
         last_clk_q <= 1'b1;
         last_dat_q <= 1'b1;
      end else if (first_smp) begin
         same_clk_q <= (pin == scl);
         same_dat_q <= (pin == sda);
         tog_clk_q  <= 1'b0;
         tog_dat_q  <= 1'b0;
         last_clk_q <= scl;
         last_dat_q <= sda;
      end else if (more_smp) begin
         same_clk_q <= same_clk_q & (pin == scl);
         same_dat_q <= same_dat_q & (pin == sda);
         tog_clk_q  <= tog_clk_q | (scl != last_clk_q);
         tog_dat_q  <= tog_dat_q | (sda != last_dat_q);
         last_clk_q <= scl;
         last_dat_q <= sda;
      end
   end

   // Clock line checked first; a line that never moved cannot prove a tie
   always_comb begin
      if (same_clk_q && tog_clk_q) begin
         code_o = STRAP_CLK;
      end else if (same_dat_q && tog_dat_q) begin
         code_o = STRAP_DAT;
      end else begin
         code_o = strap_fixed(pin);
      end
   end

endmodule

// File: rtl/strap_field_map.sv
module strap_field_map
   import strap_pkg::*;
#(
   parameter int                 PIN_CNT    = 2,
   parameter int                 PREFIX_W   = 3,
   parameter int                 GROUP_W    = 4,
   parameter logic [PREFIX_W-1:0] IN_PREFIX  = 3'b110,
   parameter logic [PREFIX_W-1:0] OUT_PREFIX = 3'b101,
   localparam int                CODES_W    = PIN_CNT * STRAP_CODE_W,
   localparam int                ADDR_W     = PREFIX_W + CODES_W,
   localparam int                VEC_W      = PIN_CNT * GROUP_W
) (
   input  logic [CODES_W-1:0] code_vec,
   output logic [ADDR_W-1:0]  in_addr,
   output logic [ADDR_W-1:0]  out_addr,
   output logic [VEC_W-1:0]   pull_en,
   output logic [VEC_W-1:0]   dflt_out
);

   assign in_addr  = {IN_PREFIX,  code_vec};
   assign out_addr = {OUT_PREFIX, code_vec};

   for (genvar p = 0; p < PIN_CNT; p++) begin : g_grp
      logic is_low;
      assign is_low = (code_vec[p*STRAP_CODE_W +: STRAP_CODE_W] == STRAP_LOW);
      assign pull_en [p*GROUP_W +: GROUP_W] = {GROUP_W{~is_low}};
      assign dflt_out[p*GROUP_W +: GROUP_W] = {GROUP_W{~is_low}};
   end

endmodule

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder
   import strap_pkg::*;
#(
   parameter int                  PIN_CNT        = 2,
   parameter int                  PREFIX_W       = 3,
   parameter int                  GROUP_W        = 4,
   parameter logic [PREFIX_W-1:0] IN_PREFIX      = 3'b110,
   parameter logic [PREFIX_W-1:0] OUT_PREFIX     = 3'b101,
   parameter bit                  FALLBACK_TRACK = 1'b1,
   localparam int                 CODES_W        = PIN_CNT * STRAP_CODE_W,
   localparam int                 ADDR_W         = PREFIX_W + CODES_W,
   localparam int                 VEC_W          = PIN_CNT * GROUP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PIN_CNT-1:0] pin_lvl,
   input  logic               scl,
   input  logic               sda,
   input  logic               start_pulse,
   input  logic               stop_pulse,
   output logic               cfg_valid,
   output logic [ADDR_W-1:0]  in_addr,
   output logic [ADDR_W-1:0]  out_addr,
   output logic [VEC_W-1:0]   pull_en,
   output logic [VEC_W-1:0]   dflt_out
);

   if (PIN_CNT < 1) begin : g_bad_pins
      $error("strap_addr_decoder: PIN_CNT must be at least 1");
   end
   if (GROUP_W < 1) begin : g_bad_group
      $error("strap_addr_decoder: GROUP_W must be at least 1");
   end
   if (PREFIX_W < 1) begin : g_bad_prefix
      $error("strap_addr_decoder: PREFIX_W must be at least 1");
   end

   logic               first_smp, more_smp, commit;
   logic [CODES_W-1:0] cls_vec;
   logic [CODES_W-1:0] fb_vec;
   logic [CODES_W-1:0] code_q;
   logic               valid_q;

   strap_txn_track u_txn (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_pulse (start_pulse),
      .stop_pulse  (stop_pulse),
      .first_smp   (first_smp),
      .more_smp    (more_smp),
      .commit      (commit)
   );

   for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
      strap_code_e code_p;

      strap_pin_class u_cls (
         .clk       (clk),
         .rst_n     (rst_n),
         .first_smp (first_smp),
         .more_smp  (more_smp),
         .pin       (pin_lvl[p]),
         .scl       (scl),
         .sda       (sda),
         .code_o    (code_p)
      );
      assign cls_vec[p*STRAP_CODE_W +: STRAP_CODE_W] = code_p;

      // Fallback before the first decode: follow the pin, or pin everything high
      if (FALLBACK_TRACK) begin : g_fb_track
         assign fb_vec[p*STRAP_CODE_W +: STRAP_CODE_W] = strap_fixed(pin_lvl[p]);
      end else begin : g_fb_const
         assign fb_vec[p*STRAP_CODE_W +: STRAP_CODE_W] = STRAP_HIGH;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= {PIN_CNT{STRAP_HIGH}};
         valid_q <= 1'b0;
      end else if (commit) begin
         code_q  <= cls_vec;
         valid_q <= 1'b1;
      end else if (!valid_q) begin
         code_q  <= fb_vec;
      end
   end

   assign cfg_valid = valid_q;

   strap_field_map #(
      .PIN_CNT    (PIN_CNT),
      .PREFIX_W   (PREFIX_W),
      .GROUP_W    (GROUP_W),
      .IN_PREFIX  (IN_PREFIX),
      .OUT_PREFIX (OUT_PREFIX)
   ) u_map (
      .code_vec (code_q),
      .in_addr  (in_addr),
      .out_addr (out_addr),
      .pull_en  (pull_en),
      .dflt_out (dflt_out)
   );

endmodule

// File: rtl/strap_addr_decoder_chk.sv
module strap_addr_decoder_chk #(
   parameter int                  PIN_CNT    = 2,
   parameter int                  PREFIX_W   = 3,
   parameter int                  GROUP_W    = 4,
   parameter logic [PREFIX_W-1:0] IN_PREFIX  = 3'b110,
   parameter logic [PREFIX_W-1:0] OUT_PREFIX = 3'b101,
   localparam int                 CODES_W    = PIN_CNT * 2,
   localparam int                 ADDR_W     = PREFIX_W + CODES_W,
   localparam int                 VEC_W      = PIN_CNT * GROUP_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_pulse,
   input logic              cfg_valid,
   input logic [ADDR_W-1:0] in_addr,
   input logic [ADDR_W-1:0] out_addr,
   input logic [VEC_W-1:0]  pull_en,
   input logic [VEC_W-1:0]  dflt_out
);

   // R6
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> cfg_valid);

   // R6
   valid_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_valid) |-> $past(stop_pulse));

   // R6
   hold_between_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !stop_pulse) |=> ($stable(in_addr) && $stable(out_addr)
                                      && $stable(pull_en) && $stable(dflt_out)));

   // R2
   fallback_fixed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid |-> (in_addr[1] && in_addr[3]));

   // R7
   addr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_addr[CODES_W-1:0] == out_addr[CODES_W-1:0])
      && (in_addr[ADDR_W-1 -: PREFIX_W] == IN_PREFIX)
      && (out_addr[ADDR_W-1 -: PREFIX_W] == OUT_PREFIX));

   // R8
   pull_low_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pull_en[GROUP_W-1:0] == '0) == (in_addr[1:0] == 2'b10))
      && ((pull_en[2*GROUP_W-1:GROUP_W] == '0) == (in_addr[3:2] == 2'b10)));

   // R9
   dflt_low_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dflt_out[GROUP_W-1:0] == '0) == (out_addr[1:0] == 2'b10))
      && ((dflt_out[2*GROUP_W-1:GROUP_W] == '0) == (out_addr[3:2] == 2'b10)));

endmodule

bind strap_addr_decoder strap_addr_decoder_chk #(
   .PIN_CNT    (PIN_CNT),
   .PREFIX_W   (PREFIX_W),
   .GROUP_W    (GROUP_W),
   .IN_PREFIX  (IN_PREFIX),
   .OUT_PREFIX (OUT_PREFIX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_pulse (stop_pulse),
   .cfg_valid  (cfg_valid),
   .in_addr    (in_addr),
   .out_addr   (out_addr),
   .pull_en    (pull_en),
   .dflt_out   (dflt_out)
);

// File: tb/strap_addr_decoder_test.sv
module strap_addr_decoder_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pin_lvl = 2'b00;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       start_pulse = 1'b0;
   logic       stop_pulse = 1'b0;
   logic       cfg_valid;
   logic [6:0] in_addr, out_addr;
   logic [7:0] pull_en, dflt_out;

   always #10 clk = ~clk;

   strap_addr_decoder uut (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .scl(scl), .sda(sda),
      .start_pulse(start_pulse), .stop_pulse(stop_pulse),
      .cfg_valid(cfg_valid), .in_addr(in_addr), .out_addr(out_addr),
      .pull_en(pull_en), .dflt_out(dflt_out)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;

   // ---------------- reference model ----------------
   logic [1:0] m_code [2];
   bit         m_valid = 0;
   bit         m_tx = 0;
   bit         q_p0[$], q_p1[$], q_c[$], q_d[$];

   function automatic logic [1:0] classify(input bit qp[$], input bit qc[$],
                                           input bit qd[$], input bit pin_now);
      bit mc = 1, md = 1, tc = 0, td = 0;
      foreach (qp[i]) begin
         if (qp[i] != qc[i]) mc = 0;
         if (qp[i] != qd[i]) md = 0;
         if (qc[i] != qc[0]) tc = 1;
         if (qd[i] != qd[0]) td = 1;
      end
      if (mc && tc) return 2'b00;
      if (md && td) return 2'b01;
      return pin_now ? 2'b11 : 2'b10;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_code[0] = 2'b11; m_code[1] = 2'b11;
         m_valid = 0; m_tx = 0;
         q_p0.delete(); q_p1.delete(); q_c.delete(); q_d.delete();
      end else if (stop_pulse && m_tx) begin
         m_code[0] = classify(q_p0, q_c, q_d, pin_lvl[0]);
         m_code[1] = classify(q_p1, q_c, q_d, pin_lvl[1]);
         m_valid = 1; m_tx = 0;
         q_p0.delete(); q_p1.delete(); q_c.delete(); q_d.delete();
      end else begin
         if (start_pulse && !m_tx) begin
            m_tx = 1;
            q_p0.delete(); q_p1.delete(); q_c.delete(); q_d.delete();
         end
         if (m_tx) begin
            q_p0.push_back(pin_lvl[0]); q_p1.push_back(pin_lvl[1]);
            q_c.push_back(scl); q_d.push_back(sda);
         end
         if (!m_valid) begin
            m_code[0] = pin_lvl[0] ? 2'b11 : 2'b10;
            m_code[1] = pin_lvl[1] ? 2'b11 : 2'b10;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] grp(input logic [1:0] c);
      return (c == 2'b10) ? 4'h0 : 4'hF;
   endfunction

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 cfg_valid model", {31'd0, cfg_valid}, {31'd0, m_valid});
         chk("R7 in_addr model", {25'd0, in_addr}, {25'd0, 3'b110, m_code[1], m_code[0]});
         chk("R7 out_addr model", {25'd0, out_addr}, {25'd0, 3'b101, m_code[1], m_code[0]});
         chk("R8 pull_en model", {24'd0, pull_en}, {24'd0, grp(m_code[1]), grp(m_code[0])});
         chk("R9 dflt_out model", {24'd0, dflt_out}, {24'd0, grp(m_code[1]), grp(m_code[0])});
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R6 act=hung exp=finished");
         finish_run();
      end
   end

   // ---------------- stimulus ----------------
   int mode_a, mode_b;  // 0 = on SCL, 1 = on SDA, 2 = fixed level
   bit lvl_a, lvl_b;

   task automatic drive_pins();
      pin_lvl[0] = (mode_a == 0) ? scl : (mode_a == 1) ? sda : lvl_a;
      pin_lvl[1] = (mode_b == 0) ? scl : (mode_b == 1) ? sda : lvl_b;
   endtask

   // pat: 0 independent lines, 1 SCL stuck high, 2 SDA copies SCL
   task automatic run_tx(input int ma, input bit la, input int mb, input bit lb,
                         input int pat, input bit extra_start);
      mode_a = ma; lvl_a = la; mode_b = mb; lvl_b = lb;
      @(negedge clk);
      scl = 1; sda = 1; drive_pins(); start_pulse = 1;
      @(negedge clk);
      start_pulse = 0;
      for (int i = 0; i < 16; i++) begin
         scl = (pat == 1) ? 1'b1 : i[1];
         sda = (pat == 2) ? scl : i[2];
         drive_pins();
         start_pulse = extra_start && (i == 8);
         @(negedge clk);
      end
      start_pulse = 0;
      scl = 1; sda = 1; drive_pins(); stop_pulse = 1;
      @(negedge clk);
      stop_pulse = 0;
   endtask

   task automatic chk_all(input string tag, input logic [6:0] ia, input logic [6:0] oa,
                          input logic [7:0] pe, input logic [7:0] dv, input bit v);
      chk({tag, " in_addr"}, {25'd0, in_addr}, {25'd0, ia});
      chk({tag, " out_addr"}, {25'd0, out_addr}, {25'd0, oa});
      chk({tag, " pull_en"}, {24'd0, pull_en}, {24'd0, pe});
      chk({tag, " dflt_out"}, {24'd0, dflt_out}, {24'd0, dv});
      chk({tag, " cfg_valid"}, {31'd0, cfg_valid}, {31'd0, v});
   endtask

   initial begin
      mode_a = 2; mode_b = 2; lvl_a = 0; lvl_b = 0;
      repeat (3) @(negedge clk);
      // R1: reset values, pins held low to show they are not followed
      chk_all("R1 reset", 7'h6F, 7'h5F, 8'hFF, 8'hFF, 1'b0);
      rst_n = 1;

      // R2: fallback follows pin levels
      pin_lvl = 2'b10;
      repeat (2) @(negedge clk);
      chk_all("R2 fallback a0 b1", 7'h6E, 7'h5E, 8'hF0, 8'hF0, 1'b0);
      pin_lvl = 2'b01;
      repeat (2) @(negedge clk);
      chk_all("R2 fallback a1 b0", 7'h6B, 7'h5B, 8'h0F, 8'h0F, 1'b0);

      // R3 R4 R7: pin 0 on SCL, pin 1 on SDA
      run_tx(0, 0, 1, 0, 0, 0);
      chk_all("R3 R4 clk/dat tie", 7'h64, 7'h54, 8'hFF, 8'hFF, 1'b1);

      // R5 R8 R9 R10: fixed low / high, repeated START mid-frame
      run_tx(2, 0, 2, 1, 0, 1);
      chk_all("R5 R10 fixed lo/hi", 7'h6E, 7'h5E, 8'hF0, 8'hF0, 1'b1);

      // R4 R8 R9: pin 0 on SDA, pin 1 low
      run_tx(1, 0, 2, 0, 0, 0);
      chk_all("R4 R9 dat tie + low", 7'h69, 7'h59, 8'h0F, 8'h0F, 1'b1);

      // R6: pins move and a stray STOP arrives with no open transmission
      pin_lvl = 2'b11;
      @(negedge clk); stop_pulse = 1;
      @(negedge clk); stop_pulse = 0;
      repeat (3) @(negedge clk);
      chk_all("R6 hold + stray stop", 7'h69, 7'h59, 8'h0F, 8'h0F, 1'b1);

      // R5: pin 0 matches SCL but SCL never toggles -> fixed high
      run_tx(0, 0, 1, 0, 1, 0);
      chk_all("R5 idle line", 7'h67, 7'h57, 8'hFF, 8'hFF, 1'b1);

      // R3: SCL and SDA identical, clock tie wins
      run_tx(1, 0, 2, 0, 2, 0);
      chk_all("R3 priority", 7'h68, 7'h58, 8'h0F, 8'h0F, 1'b1);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule